// File: doc/BRIEF.md
# Parallel Grøstl-256 Permutation Round Unit

This block evaluates one complete round of both 512-bit Grøstl permutations, P and Q, in a single clock cycle. Each 512-bit operand is treated as an 8×8 matrix of bytes. Every round performs four steps in a fixed order. First a round constant is XORed into one byte. Then every byte goes through the AES substitution box. Then each row is rotated left. Finally each column is multiplied by a circulant matrix over GF(2^8). P and Q run side by side and share one round index. They differ only in where the constant lands and what its value is.

There are two ways to use the block. In single-round mode (`chain` low when `start` is pulsed), the caller supplies the round index and both states. The result appears on the output registers one cycle later. In chained mode (`chain` high), the block ignores `round_idx` and runs ten rounds with indices 0 through 9 back to back, using its own round counter. The final states are presented ten cycles after the start.

The controller is a four-state machine:
- **IDLE**: nothing pending.
- **STEP**: a single-round result is being presented.
- **ITER**: chained rounds are in progress.
- **FINAL**: a chained result is being presented.

Transitions:
- IDLE, STEP or FINAL go to STEP on a single start, and to ITER on a chained start. Without a start they fall back to IDLE.
- ITER stays in ITER until the counter reaches the last round index, then moves to FINAL.

Top module: `grs_round_unit`

## Requirements
- R1: While reset is held, and after it is released, `out_valid` and `busy` are 0 and both output states are all-zero until the first accepted start.
- R2: A start with `chain` = 0 accepted in any state other than ITER produces `out_valid` = 1 exactly one cycle later, with `p_out`/`q_out` holding one round of P/Q applied to `p_in`/`q_in` at index `round_idx`. Starts on consecutive cycles give results on consecutive cycles.
- R3: The P round constant is the 4-bit round index zero-extended to a byte. It is XORed only into the byte at row 0, column 0 before substitution.
- R4: The Q round constant is 0xFF XOR the zero-extended round index. It is XORed only into the byte at row 7, column 0 before substitution.
- R5: Every byte of both states is replaced by the AES S-box value: the multiplicative inverse in GF(2^8) modulo 0x11B (0 maps to 0), followed by the affine map with constant 0x63.
- R6: After substitution, row r of each state is rotated left by r byte positions for r = 0..7. So the byte in column c comes from column (c+r) mod 8.
- R7: Each column is then multiplied by an 8×8 matrix whose row i, column j entry is taken from the sequence (02,02,03,04,05,03,05,07) at position (j−i) mod 8. Arithmetic is in GF(2^8) modulo 0x11B.
- R8: A start with `chain` = 1 applies ten rounds with indices 0,1,…,9 to both states and ignores `round_idx`. The single `out_valid` pulse for it comes exactly ten cycles after the start is sampled.
- R9: `busy` is 1 for the nine cycles between a chained start and its result. Any start sampled while `busy` is 1 is ignored: it causes no result pulse and does not change the chained result.
- R10: `p_out` and `q_out` keep their value in every cycle that follows a clock edge with neither an accepted start nor an iteration in progress.
- R11: Byte k of a 512-bit state (k = 0 at bits 511:504, k = 63 at bits 7:0) is the matrix element at row k mod 8, column k div 8, for both input and output.
- R12: `out_valid` is a one-cycle pulse per accepted start and is never 1 while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a single or chained computation |
| chain | input | 1 | 0: one round at `round_idx`; 1: ten rounds 0..9 |
| round_idx | input | 4 | Round index for single-round mode |
| p_in | input | 512 | P-side input state |
| q_in | input | 512 | Q-side input state |
| p_out | output | 512 | Registered P-side result |
| q_out | output | 512 | Registered Q-side result |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| busy | output | 1 | Chained rounds are in progress |

## Verification
A single-round result is due one clock edge after its start is sampled. A chained result is due ten edges after. The driver stamps every expected item with the bench cycle number at which its pulse must appear. The monitor compares that stamp against the live cycle count at every `out_valid`, sampling on the falling edge so the registered outputs have settled. Any pulse with nothing queued counts as a failure, and so does an early or late pulse; this is how ignored starts during chained iteration are caught. Hold behaviour is checked by reading the outputs several idle cycles after a result has been retired.

// File: rtl/grs_pkg.sv
package grs_pkg;

    localparam int ROWS           = 8;
    localparam int COLS           = 8;
    localparam int BYTE_W         = 8;
    localparam int STATE_W        = ROWS * COLS * BYTE_W;
    localparam int ROW_LAST_SHIFT = 7;
    localparam logic [7:0] RED_POLY   = 8'h1B;
    localparam logic [7:0] AFFINE_CST = 8'h63;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef byte_t [ROWS-1:0]  col_t;
    typedef col_t  [COLS-1:0]  mat_t;
    typedef byte_t [255:0]     sbox_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STEP,
        ST_ITER,
        ST_FINAL
    } fsm_t;

    // Multiply by x modulo the field polynomial.
    function automatic byte_t xtime(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? RED_POLY : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

    // a^254 is the inverse for a != 0 and yields 0 for a == 0.
    function automatic byte_t gf_inv(input byte_t a);
        byte_t r;
        byte_t base;
        logic [7:0] e;
        r    = 8'h01;
        base = a;
        e    = 8'd254;
        for (int i = 0; i < 8; i++) begin
            if (e[i]) r = gf_mul(r, base);
            base = gf_mul(base, base);
        end
        return r;
    endfunction

    function automatic byte_t sbox_calc(input byte_t a);
        byte_t v;
        v = gf_inv(a);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                 ^ {v[3:0], v[7:4]} ^ AFFINE_CST;
    endfunction

    function automatic sbox_t build_sbox();
        sbox_t t;
        for (int i = 0; i < 256; i++) begin
            t[i] = sbox_calc(byte_t'(i));
        end
        return t;
    endfunction

    function automatic int shift_of(input int r);
        return (r == ROWS - 1) ? ROW_LAST_SHIFT : r;
    endfunction

    // Circulant coefficient: first row rotated right by i.
    function automatic byte_t mix_coef(input int i, input int j);
        byte_t c;
        case (((j - i) % ROWS + ROWS) % ROWS)
            0:       c = 8'h02;
            1:       c = 8'h02;
            2:       c = 8'h03;
            3:       c = 8'h04;
            4:       c = 8'h05;
            5:       c = 8'h03;
            6:       c = 8'h05;
            default: c = 8'h07;
        endcase
        return c;
    endfunction

    // Multiply by a constant below 8 using doubling only.
    function automatic byte_t mul_small(input byte_t a, input byte_t k);
        byte_t x2;
        byte_t x4;
        x2 = xtime(a);
        x4 = xtime(x2);
        return (k[0] ? a : 8'h00) ^ (k[1] ? x2 : 8'h00) ^ (k[2] ? x4 : 8'h00);
    endfunction

    function automatic mat_t to_mat(input logic [STATE_W-1:0] v);
        mat_t m;
        for (int c = 0; c < COLS; c++) begin
            for (int r = 0; r < ROWS; r++) begin
                m[c][r] = v[STATE_W-1-BYTE_W*(c*ROWS+r) -: BYTE_W];
            end
        end
        return m;
    endfunction

    function automatic logic [STATE_W-1:0] from_mat(input mat_t m);
        logic [STATE_W-1:0] v;
        v = '0;
        for (int c = 0; c < COLS; c++) begin
            for (int r = 0; r < ROWS; r++) begin
                v[STATE_W-1-BYTE_W*(c*ROWS+r) -: BYTE_W] = m[c][r];
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/grs_mixcol.sv
module grs_mixcol
    import grs_pkg::*;
(
    input  col_t col_in,
    output col_t col_out
);

    always_comb begin
        for (int i = 0; i < ROWS; i++) begin
            col_out[i] = '0;
            for (int j = 0; j < ROWS; j++) begin
                col_out[i] = col_out[i] ^ mul_small(col_in[j], mix_coef(i, j));
            end
        end
    end

endmodule

// File: rtl/grs_round.sv
module grs_round
    import grs_pkg::*;
#(
    parameter bit IS_Q  = 1'b0,
    parameter int RND_W = 4
)(
    input  logic [STATE_W-1:0] state_in,
    input  logic [RND_W-1:0]   rnd,
    output logic [STATE_W-1:0] state_out
);

    localparam sbox_t SBOX   = build_sbox();
    localparam int    RC_ROW = IS_Q ? ROWS - 1 : 0;
    localparam int    RC_COL = 0;

    mat_t  m_in;
    mat_t  m_arc;
    mat_t  m_sub;
    mat_t  m_shf;
    mat_t  m_mix;
    byte_t rc;

    assign m_in = to_mat(state_in);

    always_comb begin
        rc = IS_Q ? (8'hFF ^ byte_t'(rnd)) : byte_t'(rnd);
    end

    always_comb begin
        m_arc = m_in;
        m_arc[RC_COL][RC_ROW] = m_in[RC_COL][RC_ROW] ^ rc;
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            assign m_sub[c][r] = SBOX[m_arc[c][r]];
            assign m_shf[c][r] = m_sub[(c + shift_of(r)) % COLS][r];
        end
        grs_mixcol u_mix (
            .col_in  (m_shf[c]),
            .col_out (m_mix[c])
        );
    end

    assign state_out = from_mat(m_mix);

endmodule

// File: rtl/grs_round_unit.sv
module grs_round_unit
    import grs_pkg::*;
#(
    parameter int NUM_ROUNDS = 10,
    parameter int RND_W      = 4
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               chain,
    input  logic [RND_W-1:0]   round_idx,
    input  logic [STATE_W-1:0] p_in,
    input  logic [STATE_W-1:0] q_in,
    output logic [STATE_W-1:0] p_out,
    output logic [STATE_W-1:0] q_out,
    output logic               out_valid,
    output logic               busy
);

    localparam int         NUM_PERM = 2;
    localparam logic [RND_W-1:0] LAST_RND = RND_W'(NUM_ROUNDS - 1);
    localparam logic [RND_W-1:0] ONE_RND  = RND_W'(1);

    fsm_t               state_q;
    fsm_t               state_d;
    logic [RND_W-1:0]   cnt_q;
    logic [STATE_W-1:0] p_q;
    logic [STATE_W-1:0] q_q;
    logic               iterating;
    logic               accept;
    logic [RND_W-1:0]   rnd_sel;
    logic [STATE_W-1:0] src [NUM_PERM];
    logic [STATE_W-1:0] res [NUM_PERM];

    assign iterating = (state_q == ST_ITER);
    assign accept    = start && !iterating;

    always_comb begin
        if (iterating)  rnd_sel = cnt_q;
        else if (chain) rnd_sel = '0;
        else            rnd_sel = round_idx;
        src[0] = iterating ? p_q : p_in;
        src[1] = iterating ? q_q : q_in;
    end

    for (genvar g = 0; g < NUM_PERM; g++) begin : g_perm
        grs_round #(
            .IS_Q  (g == 1),
            .RND_W (RND_W)
        ) u_perm (
            .state_in  (src[g]),
            .rnd       (rnd_sel),
            .state_out (res[g])
        );
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ITER: begin
                state_d = (cnt_q == LAST_RND) ? ST_FINAL : ST_ITER;
            end
            ST_IDLE, ST_STEP, ST_FINAL: begin
                if (accept) state_d = chain ? ST_ITER : ST_STEP;
                else        state_d = ST_IDLE;
            end
        endcase
    end

    // Datapath registers and round counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q   <= '0;
            q_q   <= '0;
            cnt_q <= '0;
        end else begin
            if (accept || iterating) begin
                p_q <= res[0];
                q_q <= res[1];
            end
            if (accept && chain) cnt_q <= ONE_RND;
            else if (iterating)  cnt_q <= cnt_q + ONE_RND;
        end
    end

    // Outputs.
    always_comb begin
        out_valid = (state_q == ST_STEP) || (state_q == ST_FINAL);
        busy      = iterating;
        p_out     = p_q;
        q_out     = q_q;
    end

endmodule

// File: rtl/grs_round_unit_chk.sv
module grs_round_unit_chk
    import grs_pkg::*;
#(
    parameter int NUM_ROUNDS = 10
)(
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               chain,
    input logic               out_valid,
    input logic               busy,
    input logic [STATE_W-1:0] p_out,
    input logic [STATE_W-1:0] q_out
);

    localparam int RUN_W = $clog2(NUM_ROUNDS) + 2;

    logic [RUN_W-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    // R1: quiet outputs while reset is held
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !busy);

    // R2: single start yields a result next cycle
    a_r2_single_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !chain && !busy) |=> (out_valid && !busy));

    // R8: chained start enters iteration
    a_r8_chain_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (start && chain && !busy) |=> (busy && !out_valid));

    // R8: end of iteration always presents a result after the full count
    a_r8_final_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (out_valid && busy_run == RUN_W'(NUM_ROUNDS - 1)));

    // R9: iteration never runs past its window
    a_r9_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run < RUN_W'(NUM_ROUNDS));

    // R10: outputs hold when nothing was accepted
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(p_out) && $stable(q_out)));

    // R12: a result pulse lasts one cycle unless restarted
    a_r12_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !start) |=> !out_valid);

    // R12: never valid and busy together
    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && busy));

endmodule

bind grs_round_unit grs_round_unit_chk #(
    .NUM_ROUNDS (NUM_ROUNDS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .chain     (chain),
    .out_valid (out_valid),
    .busy      (busy),
    .p_out     (p_out),
    .q_out     (q_out)
);

// File: tb/grs_round_unit_bench.sv
module grs_round_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NROUNDS    = 10;

    logic         clk;
    logic         rst_n;
    logic         start;
    logic         chain;
    logic [3:0]   round_idx;
    logic [511:0] p_in;
    logic [511:0] q_in;
    logic [511:0] p_out;
    logic [511:0] q_out;
    logic         out_valid;
    logic         busy;

    grs_round_unit u_grs_round_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .chain     (chain),
        .round_idx (round_idx),
        .p_in      (p_in),
        .q_in      (q_in),
        .p_out     (p_out),
        .q_out     (q_out),
        .out_valid (out_valid),
        .busy      (busy)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [511:0] p;
        logic [511:0] q;
        int           due;
        string        tag;
    } exp_t;

    exp_t         sbq[$];
    int           checks = 0;
    int           fails  = 0;
    logic [7:0]   sbx [256];
    logic [511:0] last_p;
    logic [511:0] last_q;

    function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] prod;
        prod = '0;
        for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (prod[i]) prod = prod ^ (16'h011B << (i - 8));
        return prod[7:0];
    endfunction

    function automatic logic [511:0] ref_round(input logic [511:0] s, input int rnd, input bit isq);
        logic [7:0] m [8][8];
        logic [7:0] t [8][8];
        logic [7:0] o;
        logic [7:0] c0 [8];
        logic [511:0] res;
        c0 = '{8'h02, 8'h02, 8'h03, 8'h04, 8'h05, 8'h03, 8'h05, 8'h07};
        for (int k = 0; k < 64; k++) m[k % 8][k / 8] = s[511 - 8*k -: 8];
        if (isq) m[7][0] = m[7][0] ^ (8'hFF ^ 8'(rnd));
        else     m[0][0] = m[0][0] ^ 8'(rnd);
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) m[r][c] = sbx[m[r][c]];
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) t[r][c] = m[r][(c + r) % 8];
        res = '0;
        for (int c = 0; c < 8; c++) begin
            for (int i = 0; i < 8; i++) begin
                o = '0;
                for (int j = 0; j < 8; j++) o = o ^ gm(c0[(j - i + 8) % 8], t[j][c]);
                res[511 - 8*(c*8 + i) -: 8] = o;
            end
        end
        return res;
    endfunction

    task automatic check512(input string tag, input string what,
                            input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_int(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pops expected items as results appear.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sbq.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R9 unexpected out_valid at cycle actual=%0d expected=none", cyc);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check_int(e.tag, "result cycle", cyc, e.due);
                check512(e.tag, "p_out", p_out, e.p);
                check512(e.tag, "q_out", q_out, e.q);
                check_int("R12", "busy with valid", int'(busy), 0);
                last_p = e.p;
                last_q = e.q;
            end
        end
    end

    task automatic issue_single(input logic [511:0] p, input logic [511:0] q,
                                input int idx, input string tag);
        exp_t e;
        start     = 1'b1;
        chain     = 1'b0;
        round_idx = 4'(idx);
        p_in      = p;
        q_in      = q;
        e.p   = ref_round(p, idx, 1'b0);
        e.q   = ref_round(q, idx, 1'b1);
        e.due = cyc + 1;
        e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
    endtask

    task automatic issue_chain(input logic [511:0] p, input logic [511:0] q,
                               input int dummy_idx, input string tag);
        exp_t e;
        start     = 1'b1;
        chain     = 1'b1;
        round_idx = 4'(dummy_idx);
        p_in      = p;
        q_in      = q;
        e.p = p;
        e.q = q;
        for (int r = 0; r < NROUNDS; r++) begin
            e.p = ref_round(e.p, r, 1'b0);
            e.q = ref_round(e.q, r, 1'b1);
        end
        e.due = cyc + NROUNDS;
        e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
    endtask

    task automatic quiet(input int n);
        start = 1'b0;
        chain = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [511:0] pattern(input int kind, input int seed);
        logic [511:0] v;
        v = '0;
        for (int k = 0; k < 64; k++) begin
            case (kind)
                0: v[511 - 8*k -: 8] = 8'(k);
                1: v[511 - 8*k -: 8] = 8'(k * 37 + seed * 11 + (k >> 3) * 5);
                default: v[511 - 8*k -: 8] = 8'((k * k + seed) ^ (seed << 2));
            endcase
        end
        return v;
    endfunction

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog expired actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] inv;
        logic [7:0] aff;
        logic [511:0] one_byte;
        rst_n     = 1'b0;
        start     = 1'b0;
        chain     = 1'b0;
        round_idx = '0;
        p_in      = '0;
        q_in      = '0;
        last_p    = '0;
        last_q    = '0;

        // Bench S-box by exhaustive inverse search and bitwise affine map.
        for (int a = 0; a < 256; a++) begin
            inv = '0;
            for (int b = 1; b < 256; b++) if (gm(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
            for (int i = 0; i < 8; i++)
                aff[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                       ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 0;
            sbx[a] = aff;
        end

        repeat (3) @(negedge clk);
        // R1: state during reset
        check_int("R1", "out_valid in reset", int'(out_valid), 0);
        check_int("R1", "busy in reset", int'(busy), 0);
        check512("R1", "p_out in reset", p_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check512("R1", "q_out after reset", q_out, '0);
        check_int("R1", "out_valid after reset", int'(out_valid), 0);

        // R3/R4: all-zero state exposes constant placement
        issue_single('0, '0, 7, "R3_R4_zero_state");
        quiet(2);
        // R5: all-ones bytes
        issue_single({64{8'hFF}}, {64{8'hFF}}, 0, "R5_all_ff");
        quiet(2);
        // R6: distinct bytes everywhere reveal row rotation
        issue_single(pattern(0, 0), pattern(1, 3), 4, "R6_ramp");
        quiet(2);
        // R7 and R11: one nonzero byte at position 9 (row 1, column 1)
        one_byte = '0;
        one_byte[511 - 8*9 -: 8] = 8'h5A;
        issue_single(one_byte, one_byte, 15, "R7_R11_one_byte");
        quiet(2);
        // R2: back-to-back single starts
        issue_single(pattern(1, 1), pattern(2, 2), 9, "R2_b2b_first");
        issue_single(pattern(2, 5), pattern(1, 6), 1, "R2_b2b_second");
        quiet(2);

        // R10: outputs hold across idle cycles
        quiet(4);
        check512("R10", "p_out hold", p_out, last_p);
        check512("R10", "q_out hold", q_out, last_q);

        // R8: chained ten rounds, round_idx ignored
        issue_chain(pattern(1, 9), pattern(0, 0), 6, "R8_chain");
        quiet(2);
        // R9: busy during iteration, interfering start ignored
        check_int("R9", "busy mid-chain", int'(busy), 1);
        start     = 1'b1;
        chain     = 1'b0;
        round_idx = 4'd3;
        p_in      = pattern(2, 77);
        q_in      = pattern(2, 78);
        @(negedge clk);
        start = 1'b1;
        chain = 1'b1;
        @(negedge clk);
        quiet(12);

        // R2: single start right after a chained result from FINAL state
        issue_chain(pattern(2, 4), pattern(1, 8), 0, "R8_chain_second");
        quiet(NROUNDS - 1);
        issue_single(pattern(0, 0), '0, 2, "R2_after_final");
        quiet(4);

        check_int("R9", "pending results", sbq.size(), 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule